// File: doc/BRIEF.md
# Edge/Level Interrupt Request Latch

This block holds one pending-request bit for each of eight interrupt lines. Each line has its own trigger mode. An edge line records a request when its input goes from low to high. A level line's request simply tracks the input. Next to the request bits the block keeps the input level it saw on the previous clock, and it uses that stored level to detect rising transitions. A priority resolver further along the interrupt path reads the request bits. When the resolver services a line, it sends an acknowledge carrying that line's index.

A host programs the trigger modes through an 8-bit trigger-select register. A bit set to 1 makes its line level triggered. A fixed per-instance writable mask limits which bits can ever be set, so lines whose bit is 0 in the mask always stay edge triggered. The block has no streaming data path. The write strobe, the acknowledge strobe and the input lines are plain single-cycle pins with no back-pressure. Each of them acts on the rising clock edge at which it is sampled.

Top module: `irq_req_latch`

## Requirements
- R1: While reset is asserted, and immediately after it is released, every request bit reads 0 and the trigger-select readback reads 0, which makes every line edge triggered.
- R2: On an edge line, a high input whose previously sampled level was low sets the request bit at the next clock edge.
- R3: On an edge line, an input that stays high after its request has been acknowledged does not set the request again.
- R4: On an edge line, a low input leaves the request bit unchanged and records the level as low.
- R5: On a level line (trigger-select bit 1), the request bit after each clock edge equals the input sampled at that edge.
- R6: An acknowledge (`ack_valid` high, `ack_idx` = line number 0..7) clears the request bit of an edge line at the next clock edge.
- R7: An acknowledge addressed to a level line has no effect on its request bit.
- R8: When an acknowledge and a rising transition hit the same edge line in the same cycle, the acknowledge clear is applied first, so the request remains set.
- R9: A trigger-select write stores `cfg_wr_data` ANDed with the writable mask (default 8'hF8, so bits 0..2 stay 0). The stored value reads back from the next cycle onward, and from that cycle onward it governs the line modes.
- R10: An acknowledge changes only the line it addresses. All other request bits behave as if no acknowledge were present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Raw interrupt input levels, one per line |
| cfg_wr_en | input | 1 | Trigger-select write strobe |
| cfg_wr_data | input | 8 | Trigger-select write value (bit 1 = level) |
| cfg_rd_data | output | 8 | Current trigger-select register |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_idx | input | 3 | Index of the acknowledged line |
| req_o | output | 8 | Pending request bits |

## Verification
A stale last-level bit shows up on an edge line as either a missing request or an extra one. This is visible on `req_o` one cycle after the next high input on that line, and R3 and R2 observe it. A trigger-select bit that is wrong, or that is wrongly masked, first shows on `cfg_rd_data` in the cycle after the write. It then shows in the line's behaviour: an acknowledge on that line either fails to clear it (R6) or wrongly clears it (R7), and a low input either leaves the request set (R4) or drops it (R5). The stimulus sequence makes each of these state errors appear at the ports within two cycles of the stimulus that exposes it.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;

  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_mode_e;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/irq_trig_reg.sv
module irq_trig_reg #(
  parameter int                    NUM_LINES = 8,
  parameter logic [NUM_LINES-1:0]  WMASK     = 8'hF8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [NUM_LINES-1:0] wr_data,
  output logic [NUM_LINES-1:0] trig_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)     trig_q <= '0;
    else if (wr_en) trig_q <= wr_data & WMASK;
  end

  p_masked_store_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (trig_q == ($past(wr_data) & WMASK)));

endmodule

// File: rtl/irq_ack_dec.sv
module irq_ack_dec #(
  parameter int NUM_LINES = 8,
  parameter int IDX_W     = 3
) (
  input  logic                 ack_valid,
  input  logic [IDX_W-1:0]     ack_idx,
  output logic [NUM_LINES-1:0] ack_hit
);

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_hit
    assign ack_hit[g] = ack_valid && (ack_idx == IDX_W'(g));
  end

endmodule

// File: rtl/irq_line_cell.sv
module irq_line_cell
  import irq_latch_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mode,
  input  logic irq_in,
  input  logic ack_hit,
  output logic req_q
);

  trig_mode_e mode_e;
  logic       last_q;
  logic       req_d;

  assign mode_e = trig_mode_e'(mode);

  // Acknowledge clear first, then a rising transition may set again.
  always_comb begin
    if (mode_e == TRIG_LEVEL) begin
      req_d = irq_in;
    end else begin
      req_d = req_q & ~ack_hit;
      if (irq_in && !last_q) req_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      last_q <= 1'b0;
    end else begin
      req_q  <= req_d;
      last_q <= irq_in;
    end
  end

  p_edge_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode && irq_in && !last_q) |=> req_q);

  p_edge_low_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode && !irq_in && !ack_hit) |=> $stable(req_q));

  p_level_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mode |=> (req_q == $past(irq_in)));

  p_ack_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode && ack_hit && !(irq_in && !last_q)) |=> !req_q);

endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch
  import irq_latch_pkg::*;
#(
  parameter int                   NUM_LINES  = 8,
  parameter logic [NUM_LINES-1:0] TRIG_WMASK = 8'hF8,
  localparam int                  IDX_W      = idx_width(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 cfg_wr_en,
  input  logic [NUM_LINES-1:0] cfg_wr_data,
  output logic [NUM_LINES-1:0] cfg_rd_data,
  input  logic                 ack_valid,
  input  logic [IDX_W-1:0]     ack_idx,
  output logic [NUM_LINES-1:0] req_o
);

  logic [NUM_LINES-1:0] trig_q;
  logic [NUM_LINES-1:0] ack_hit;

  irq_trig_reg #(.NUM_LINES(NUM_LINES), .WMASK(TRIG_WMASK)) u_trig (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr_en),
    .wr_data (cfg_wr_data),
    .trig_q  (trig_q)
  );

  irq_ack_dec #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_ack (
    .ack_valid (ack_valid),
    .ack_idx   (ack_idx),
    .ack_hit   (ack_hit)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    irq_line_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode    (trig_q[g]),
      .irq_in  (irq_in[g]),
      .ack_hit (ack_hit[g]),
      .req_q   (req_o[g])
    );
  end

  assign cfg_rd_data = trig_q;

  p_ack_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_hit) && (ack_valid || (ack_hit == '0)));

endmodule

// File: tb/irq_req_latch_bench.sv
`timescale 1ns/1ps
module irq_req_latch_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_in = '0;
  logic       cfg_wr_en = 1'b0;
  logic [7:0] cfg_wr_data = '0;
  logic [7:0] cfg_rd_data;
  logic       ack_valid = 1'b0;
  logic [2:0] ack_idx = '0;
  logic [7:0] req_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] q_req[$];
  logic [7:0] q_trig[$];
  string      q_tag[$];

  always #2.5 clk = ~clk;

  irq_req_latch u_irq_req_latch (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data), .cfg_rd_data(cfg_rd_data),
    .ack_valid(ack_valid), .ack_idx(ack_idx), .req_o(req_o)
  );

  // Driver: apply one cycle of stimulus, queue the result expected after the edge.
  task automatic step(input logic [7:0] in, input logic av, input logic [2:0] ai,
                      input logic we, input logic [7:0] wd,
                      input logic [7:0] exp_req, input logic [7:0] exp_trig,
                      input string tag);
    irq_in = in; ack_valid = av; ack_idx = ai;
    cfg_wr_en = we; cfg_wr_data = wd;
    q_req.push_back(exp_req);
    q_trig.push_back(exp_trig);
    q_tag.push_back(tag);
    @(negedge clk);
  endtask

  // Monitor: compare just after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q_req.size() > 0) begin
        logic [7:0] er, et;
        string t;
        er = q_req.pop_front();
        et = q_trig.pop_front();
        t  = q_tag.pop_front();
        checks++;
        if (req_o !== er || cfg_rd_data !== et) begin
          errors++;
          $display("FAIL %s: req=%h exp=%h trig=%h exp=%h", t, req_o, er, cfg_rd_data, et);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    step(8'h00, 0, 0, 0, 8'h00, 8'h00, 8'h00, "R1 in reset");
    rst_n = 1'b1;
    step(8'h00, 0, 0, 0, 8'h00, 8'h00, 8'h00, "R1 after release");
    step(8'h01, 0, 0, 0, 8'h00, 8'h01, 8'h00, "R2 rise line0");
    step(8'h01, 1, 0, 0, 8'h00, 8'h00, 8'h00, "R6 ack line0");
    step(8'h01, 0, 0, 0, 8'h00, 8'h00, 8'h00, "R3 held high no reset");
    step(8'h00, 0, 0, 0, 8'h00, 8'h00, 8'h00, "R4 low");
    step(8'h04, 0, 0, 0, 8'h00, 8'h04, 8'h00, "R2 rise line2");
    step(8'h00, 0, 0, 0, 8'h00, 8'h04, 8'h00, "R4 low keeps request");
    step(8'h20, 1, 5, 0, 8'h00, 8'h24, 8'h00, "R8 ack with rise line5");
    step(8'h20, 1, 2, 0, 8'h00, 8'h20, 8'h00, "R10 ack line2 only");
    step(8'h20, 0, 0, 1, 8'hFF, 8'h20, 8'hF8, "R9 masked write");
    step(8'h20, 0, 0, 0, 8'h00, 8'h20, 8'hF8, "R5 level high");
    step(8'h00, 0, 0, 0, 8'h00, 8'h00, 8'hF8, "R5 level low clears");
    step(8'h30, 0, 0, 0, 8'h00, 8'h30, 8'hF8, "R5 level two lines");
    step(8'h30, 1, 5, 0, 8'h00, 8'h30, 8'hF8, "R7 ack level line5");
    step(8'h30, 1, 4, 0, 8'h00, 8'h30, 8'hF8, "R7 ack level line4");
    step(8'h00, 0, 0, 0, 8'h00, 8'h00, 8'hF8, "R5 level release");
    step(8'h00, 0, 0, 1, 8'h02, 8'h00, 8'h00, "R9 masked bit1");
    step(8'h02, 0, 0, 0, 8'h00, 8'h02, 8'h00, "R2 line1 stays edge");
    step(8'h00, 0, 0, 0, 8'h00, 8'h02, 8'h00, "R4 line1 edge hold");
    step(8'h00, 1, 1, 0, 8'h00, 8'h00, 8'h00, "R6 ack line1");
    step(8'h00, 0, 0, 0, 8'h00, 8'h00, 8'h00, "R10 idle");
    wait (q_req.size() == 0);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule